// File: doc/BRIEF.md
# Real-Time Clock Calendar Core

This core keeps the time of day and a one-hundred-year calendar for a larger chip. A prescaler outside the block supplies a strobe on `secTick`; every clock cycle in which that strobe is high counts as one elapsed second. Each accepted second advances seconds, minutes, hours, day of the week, day of the month, month and year, with carries between them. Month lengths and leap years are handled in hardware. A one-cycle `updateDone` strobe marks each completed advance, and the interrupt logic can use it.

Software sees every field as an 8-bit value. Two mode inputs choose how values are shown and read: binary or two-digit BCD, and a 24-hour clock or a 12-hour clock with a PM flag. An optional daylight-saving rule moves the hour forward on the first Sunday of April and back on the last Sunday of October. To set the clock, the host raises `holdUpdate`, which stops the counting. It then writes each field through a small write port with a field selector. Because of the hold, no carry can land between two writes.

Top module: `rtc_calendar_core`

## Requirements
- R1: Each accepted tick adds one second. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the day.
- R2: At the day carry, the date wraps to 1 after the last day of the month. April, June, September and November have 30 days, and every month except February has 31 days if not in that list. Month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R3: February has 29 days when the year value is a multiple of 4 (00 included) and 28 days otherwise.
- R4: Day of week runs from 1 to 7 (1 is Sunday) and steps at every day carry, with 7 followed by 1.
- R5: When `bcdMode`=1, every field is read and written as two BCD digits, with the tens digit in bits [7:4] and the units digit in bits [3:0]. When `bcdMode`=0, fields are plain binary.
- R6: When `mode24`=1, hours read 0..23 with bit 7 clear. When `mode24`=0, bit 7 of the hours field is the PM flag and bits [6:0] run 12, 1, ..., 11 in the selected encoding. Midnight reads as 12 with bit 7 clear, and noon reads as 12 with bit 7 set. Hour writes follow the same layout.
- R7: While `holdUpdate`=1, ticks are discarded and every field keeps its value.
- R8: While `holdUpdate`=1, a cycle with `wrEn`=1 loads `wrData` into the field chosen by `wrSel`, read in the current format. The codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. A write with `holdUpdate`=0 is ignored.
- R9: `updateDone` is high for exactly the one clock after each accepted tick, and the new field values are visible in that same cycle.
- R10: With `dstEnable`=1, on a Sunday in April with date 1..7, the tick that leaves 01:59:59 lands on 03:00:00.
- R11: With `dstEnable`=1, on a Sunday in October with date 25..31, the first tick that leaves 01:59:59 lands on 01:00:00. The next pass through 01:59:59 continues to 02:00:00.
- R12: After reset the clock reads 00:00:00, day of week 1, date 1, month 1, year 0, and `updateDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One second elapsed (counted once per clock cycle it is high) |
| holdUpdate | input | 1 | Freezes counting and enables field writes |
| bcdMode | input | 1 | 1 = BCD view of the fields, 0 = binary view |
| mode24 | input | 1 | 1 = 24-hour view, 0 = 12-hour view with PM flag |
| dstEnable | input | 1 | Enables the daylight-saving shifts |
| wrEn | input | 1 | Field write strobe |
| wrSel | input | 3 | Field selector for writes |
| wrData | input | 8 | Field write value in the current format |
| secondsOut | output | 8 | Seconds field |
| minutesOut | output | 8 | Minutes field |
| hoursOut | output | 8 | Hours field (bit 7 = PM in 12-hour view) |
| weekdayOut | output | 8 | Day-of-week field |
| dateOut | output | 8 | Day-of-month field |
| monthOut | output | 8 | Month field |
| yearOut | output | 8 | Year field |
| updateDone | output | 1 | One-cycle strobe after each advance |

## Verification
The bench goes after the carry chain at its far end: 23:59:59 on 31 December of year 99, 30-day month ends, and February in leap and common years, year 00 included. A design with a wrong month table or leap test would show a 31st of April or skip 29 February. The 12-hour view is driven through midnight and noon in both encodings, where an off-by-one shows up as hour 0 or a PM flag on the wrong side. The daylight-saving tests drive the spring jump and the fall repeat. The fall case is run twice through 01:59:59 to catch a core that repeats the hour forever or never repeats it. Ticks and writes are also sent while the hold is raised and while it is low, to prove that each is ignored in the state where it should be.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned SEC_PER_MIN     = 60;
  localparam int unsigned MIN_PER_HOUR    = 60;
  localparam int unsigned HOUR_PER_DAY    = 24;
  localparam int unsigned DAYS_PER_WEEK   = 7;
  localparam int unsigned MONTHS_PER_YEAR = 12;
  localparam int unsigned YEAR_SPAN       = 100;
  localparam int unsigned LEAP_STEP       = 4;
  localparam int unsigned HALF_DAY        = HOUR_PER_DAY / 2;

  localparam int unsigned SEC_W   = $clog2(SEC_PER_MIN);
  localparam int unsigned MIN_W   = $clog2(MIN_PER_HOUR);
  localparam int unsigned HOUR_W  = $clog2(HOUR_PER_DAY);
  localparam int unsigned DOW_W   = $clog2(DAYS_PER_WEEK + 1);
  localparam int unsigned DATE_W  = 5;
  localparam int unsigned MON_W   = $clog2(MONTHS_PER_YEAR + 1);
  localparam int unsigned YEAR_W  = $clog2(YEAR_SPAN);
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned VAL_W   = FIELD_W - 1;

  // Daylight-saving rule points (Sunday is day 1)
  localparam int unsigned SUNDAY         = 1;
  localparam int unsigned SPRING_MONTH   = 4;
  localparam int unsigned SPRING_MAXDATE = 7;
  localparam int unsigned FALL_MONTH     = 10;
  localparam int unsigned FALL_MINDATE   = 25;
  localparam int unsigned SHIFT_HOUR     = 1;
  localparam int unsigned SPRING_TARGET  = 3;

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6
  } fieldSel_e;

  typedef struct packed {
    logic advance;    // normal one-second step
    logic springFwd;  // jump 01:59:59 -> 03:00:00
    logic fallBack;   // repeat 01:00:00
    logic load;       // host field write
  } rtcStrobe_t;

  function automatic logic [FIELD_W-1:0] toBcd(input logic [VAL_W-1:0] v);
    return {4'(v / VAL_W'(10)), 4'(v % VAL_W'(10))};
  endfunction

  function automatic logic [VAL_W-1:0] fromBcd(input logic [FIELD_W-1:0] b);
    return VAL_W'(b[7:4]) * VAL_W'(10) + VAL_W'(b[3:0]);
  endfunction

  function automatic logic [FIELD_W-1:0] encodeField(input logic [VAL_W-1:0] v,
                                                     input logic bcd);
    return bcd ? toBcd(v) : {1'b0, v};
  endfunction

endpackage

// File: rtl/rtc_control.sv
module rtc_control
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       holdUpdate,
  input  logic       wrEn,
  input  logic       dstEnable,
  input  logic       atSpringPoint,
  input  logic       atFallPoint,
  output rtcStrobe_t strobe,
  output logic       updateDone
);

  logic tickAccepted;
  logic fallDone;

  assign tickAccepted = secTick && !holdUpdate;

  always_comb begin
    strobe.springFwd = tickAccepted && dstEnable && atSpringPoint;
    strobe.fallBack  = tickAccepted && dstEnable && atFallPoint && !fallDone;
    strobe.advance   = tickAccepted && !strobe.springFwd && !strobe.fallBack;
    strobe.load      = wrEn && holdUpdate;
  end

  // fallDone marks that the October hour has already been repeated once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallDone   <= 1'b0;
      updateDone <= 1'b0;
    end else begin
      updateDone <= tickAccepted;
      if (strobe.fallBack)
        fallDone <= 1'b1;
      else if (strobe.load)
        fallDone <= 1'b0;
      else if (tickAccepted && atFallPoint && fallDone)
        fallDone <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  rtcStrobe_t         strobe,
  input  logic [2:0]         wrSel,
  input  logic [FIELD_W-1:0] wrData,
  input  logic               bcdMode,
  input  logic               mode24,
  output logic [SEC_W-1:0]   secBin,
  output logic [MIN_W-1:0]   minBin,
  output logic [HOUR_W-1:0]  hourBin,
  output logic [DOW_W-1:0]   dowBin,
  output logic [DATE_W-1:0]  dateBin,
  output logic [MON_W-1:0]   monthBin,
  output logic [YEAR_W-1:0]  yearBin,
  output logic               atSpringPoint,
  output logic               atFallPoint,
  output logic [FIELD_W-1:0] secondsOut,
  output logic [FIELD_W-1:0] minutesOut,
  output logic [FIELD_W-1:0] hoursOut,
  output logic [FIELD_W-1:0] weekdayOut,
  output logic [FIELD_W-1:0] dateOut,
  output logic [FIELD_W-1:0] monthOut,
  output logic [FIELD_W-1:0] yearOut
);

  // ---------------- carry chain ----------------
  logic              secWrap, minWrap, dayWrap, dateWrap, monthWrap;
  logic              leapYear;
  logic [DATE_W-1:0] monthLen;
  logic              lastSecondOfShiftHour;

  assign leapYear = (yearBin % YEAR_W'(LEAP_STEP)) == '0;

  always_comb begin
    unique case (monthBin)
      MON_W'(2):                                   monthLen = leapYear ? DATE_W'(29) : DATE_W'(28);
      MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): monthLen = DATE_W'(30);
      default:                                     monthLen = DATE_W'(31);
    endcase
  end

  assign secWrap   = secBin == SEC_W'(SEC_PER_MIN - 1);
  assign minWrap   = secWrap && (minBin == MIN_W'(MIN_PER_HOUR - 1));
  assign dayWrap   = minWrap && (hourBin == HOUR_W'(HOUR_PER_DAY - 1));
  assign dateWrap  = dayWrap && (dateBin == monthLen);
  assign monthWrap = dateWrap && (monthBin == MON_W'(MONTHS_PER_YEAR));

  assign lastSecondOfShiftHour = minWrap && (hourBin == HOUR_W'(SHIFT_HOUR));
  assign atSpringPoint = lastSecondOfShiftHour
                      && (monthBin == MON_W'(SPRING_MONTH))
                      && (dowBin == DOW_W'(SUNDAY))
                      && (dateBin <= DATE_W'(SPRING_MAXDATE));
  assign atFallPoint   = lastSecondOfShiftHour
                      && (monthBin == MON_W'(FALL_MONTH))
                      && (dowBin == DOW_W'(SUNDAY))
                      && (dateBin >= DATE_W'(FALL_MINDATE));

  // ---------------- write decode ----------------
  logic [VAL_W-1:0]  wrPlain;
  logic [VAL_W-1:0]  wrHourLow;
  logic [VAL_W-1:0]  wrHour12;
  logic [HOUR_W-1:0] wrHour;

  always_comb begin
    wrPlain   = bcdMode ? fromBcd(wrData) : wrData[VAL_W-1:0];
    wrHourLow = bcdMode ? fromBcd({1'b0, wrData[VAL_W-1:0]}) : wrData[VAL_W-1:0];
    wrHour12  = ((wrHourLow == VAL_W'(HALF_DAY)) ? '0 : wrHourLow)
              + (wrData[FIELD_W-1] ? VAL_W'(HALF_DAY) : '0);
    wrHour    = mode24 ? HOUR_W'(wrPlain) : HOUR_W'(wrHour12);
  end

  // ---------------- counters ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secBin   <= '0;
      minBin   <= '0;
      hourBin  <= '0;
      dowBin   <= DOW_W'(1);
      dateBin  <= DATE_W'(1);
      monthBin <= MON_W'(1);
      yearBin  <= '0;
    end else if (strobe.load) begin
      unique case (fieldSel_e'(wrSel))
        SEL_SEC:   secBin   <= SEC_W'(wrPlain);
        SEL_MIN:   minBin   <= MIN_W'(wrPlain);
        SEL_HOUR:  hourBin  <= wrHour;
        SEL_DOW:   dowBin   <= DOW_W'(wrPlain);
        SEL_DATE:  dateBin  <= DATE_W'(wrPlain);
        SEL_MONTH: monthBin <= MON_W'(wrPlain);
        SEL_YEAR:  yearBin  <= YEAR_W'(wrPlain);
        default:   ;
      endcase
    end else if (strobe.springFwd) begin
      secBin  <= '0;
      minBin  <= '0;
      hourBin <= HOUR_W'(SPRING_TARGET);
    end else if (strobe.fallBack) begin
      secBin <= '0;
      minBin <= '0;
    end else if (strobe.advance) begin
      secBin <= secWrap ? '0 : secBin + SEC_W'(1);
      if (secWrap)
        minBin <= (minBin == MIN_W'(MIN_PER_HOUR - 1)) ? '0 : minBin + MIN_W'(1);
      if (minWrap)
        hourBin <= (hourBin == HOUR_W'(HOUR_PER_DAY - 1)) ? '0 : hourBin + HOUR_W'(1);
      if (dayWrap) begin
        dowBin  <= (dowBin == DOW_W'(DAYS_PER_WEEK)) ? DOW_W'(1) : dowBin + DOW_W'(1);
        dateBin <= (dateBin == monthLen) ? DATE_W'(1) : dateBin + DATE_W'(1);
      end
      if (dateWrap)
        monthBin <= (monthBin == MON_W'(MONTHS_PER_YEAR)) ? MON_W'(1) : monthBin + MON_W'(1);
      if (monthWrap)
        yearBin <= (yearBin == YEAR_W'(YEAR_SPAN - 1)) ? '0 : yearBin + YEAR_W'(1);
    end
  end

  // ---------------- read encode ----------------
  logic [VAL_W-1:0]   hourMod;
  logic [VAL_W-1:0]   hour12;
  logic [FIELD_W-1:0] hour12Enc;
  logic               isPm;

  always_comb begin
    isPm      = hourBin >= HOUR_W'(HALF_DAY);
    hourMod   = isPm ? VAL_W'(hourBin) - VAL_W'(HALF_DAY) : VAL_W'(hourBin);
    hour12    = (hourMod == '0) ? VAL_W'(HALF_DAY) : hourMod;
    hour12Enc = encodeField(hour12, bcdMode);

    secondsOut = encodeField(VAL_W'(secBin), bcdMode);
    minutesOut = encodeField(VAL_W'(minBin), bcdMode);
    hoursOut   = mode24 ? encodeField(VAL_W'(hourBin), bcdMode)
                        : {isPm, hour12Enc[VAL_W-1:0]};
    weekdayOut = encodeField(VAL_W'(dowBin), bcdMode);
    dateOut    = encodeField(VAL_W'(dateBin), bcdMode);
    monthOut   = encodeField(VAL_W'(monthBin), bcdMode);
    yearOut    = encodeField(VAL_W'(yearBin), bcdMode);
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       holdUpdate,
  input  logic       bcdMode,
  input  logic       mode24,
  input  logic       dstEnable,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  output logic [7:0] secondsOut,
  output logic [7:0] minutesOut,
  output logic [7:0] hoursOut,
  output logic [7:0] weekdayOut,
  output logic [7:0] dateOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut,
  output logic       updateDone
);

  rtcStrobe_t        strobe;
  logic              atSpringPoint;
  logic              atFallPoint;
  logic [SEC_W-1:0]  secBin;
  logic [MIN_W-1:0]  minBin;
  logic [HOUR_W-1:0] hourBin;
  logic [DOW_W-1:0]  dowBin;
  logic [DATE_W-1:0] dateBin;
  logic [MON_W-1:0]  monthBin;
  logic [YEAR_W-1:0] yearBin;

  rtc_control u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .secTick       (secTick),
    .holdUpdate    (holdUpdate),
    .wrEn          (wrEn),
    .dstEnable     (dstEnable),
    .atSpringPoint (atSpringPoint),
    .atFallPoint   (atFallPoint),
    .strobe        (strobe),
    .updateDone    (updateDone)
  );

  rtc_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrSel         (wrSel),
    .wrData        (wrData),
    .bcdMode       (bcdMode),
    .mode24        (mode24),
    .secBin        (secBin),
    .minBin        (minBin),
    .hourBin       (hourBin),
    .dowBin        (dowBin),
    .dateBin       (dateBin),
    .monthBin      (monthBin),
    .yearBin       (yearBin),
    .atSpringPoint (atSpringPoint),
    .atFallPoint   (atFallPoint),
    .secondsOut    (secondsOut),
    .minutesOut    (minutesOut),
    .hoursOut      (hoursOut),
    .weekdayOut    (weekdayOut),
    .dateOut       (dateOut),
    .monthOut      (monthOut),
    .yearOut       (yearOut)
  );

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              secTick,
  input logic              holdUpdate,
  input logic              wrEn,
  input logic              updateDone,
  input logic [SEC_W-1:0]  secBin,
  input logic [MIN_W-1:0]  minBin,
  input logic [HOUR_W-1:0] hourBin,
  input logic [DOW_W-1:0]  dowBin,
  input logic [DATE_W-1:0] dateBin,
  input logic [MON_W-1:0]  monthBin,
  input logic [YEAR_W-1:0] yearBin
);

  logic accepted;
  logic endOfDay;
  assign accepted = secTick && !holdUpdate;
  assign endOfDay = (hourBin == HOUR_W'(HOUR_PER_DAY - 1))
                 && (minBin == MIN_W'(MIN_PER_HOUR - 1))
                 && (secBin == SEC_W'(SEC_PER_MIN - 1));

  // R1
  sec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && secBin != SEC_W'(SEC_PER_MIN - 1)) |=> secBin == $past(secBin) + SEC_W'(1));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdUpdate && !wrEn) |=> ($stable(secBin) && $stable(minBin) && $stable(hourBin)
      && $stable(dowBin) && $stable(dateBin) && $stable(monthBin) && $stable(yearBin)));

  // R8
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !holdUpdate && !secTick) |=> ($stable(secBin) && $stable(minBin) && $stable(hourBin)
      && $stable(dowBin) && $stable(dateBin) && $stable(monthBin) && $stable(yearBin)));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateDone |-> $past(accepted));

  // R9
  done_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> updateDone);

  // R3
  leap_day_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && endOfDay && monthBin == MON_W'(2) && dateBin == DATE_W'(28)
      && (yearBin % YEAR_W'(LEAP_STEP)) == '0) |=> dateBin == DATE_W'(29));

  // R4
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && endOfDay && dowBin == DOW_W'(DAYS_PER_WEEK)) |=> dowBin == DOW_W'(1));

endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .secTick    (secTick),
  .holdUpdate (holdUpdate),
  .wrEn       (wrEn),
  .updateDone (updateDone),
  .secBin     (secBin),
  .minBin     (minBin),
  .hourBin    (hourBin),
  .dowBin     (dowBin),
  .dateBin    (dateBin),
  .monthBin   (monthBin),
  .yearBin    (yearBin)
);

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;

  logic       clk = 1'b0;
  logic       rstN, secTick, holdUpdate, bcdMode, mode24, dstEnable, wrEn;
  logic [2:0] wrSel;
  logic [7:0] wrData;
  logic [7:0] secondsOut, minutesOut, hoursOut, weekdayOut, dateOut, monthOut, yearOut;
  logic       updateDone;

  always #10 clk = ~clk; // 50 MHz

  rtc_calendar_core dut (.*);

  // reference model state
  int ms, mm, mh, mdw, mdt, mmo, my, mfd, mupd;
  int vectors = 0;
  int errors  = 0;
  string phase = "R12 reset";
  bit finished = 0;

  function automatic int bcdOf(int v);  return (v / 10) * 16 + v % 10; endfunction
  function automatic int binOf(int b);  return (b / 16) * 10 + b % 16; endfunction
  function automatic int view(int v);   return bcdMode ? bcdOf(v) : v;  endfunction
  function automatic int readIn(int d); return bcdMode ? binOf(d) : (d % 128); endfunction

  function automatic int daysIn(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int hourView();
    int h;
    if (mode24) return view(mh);
    h = mh % 12;
    if (h == 0) h = 12;
    return (mh >= 12 ? 128 : 0) + view(h);
  endfunction

  task automatic modelStep();
    bit spring, fall;
    if (!rstN) begin
      ms = 0; mm = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; my = 0; mfd = 0; mupd = 0;
      return;
    end
    mupd = 0;
    if (secTick && !holdUpdate) begin
      mupd   = 1;
      spring = (mmo == 4)  && (mdw == 1) && (mdt <= 7)  && (mh == 1) && (mm == 59) && (ms == 59);
      fall   = (mmo == 10) && (mdw == 1) && (mdt >= 25) && (mh == 1) && (mm == 59) && (ms == 59);
      if (dstEnable && spring) begin
        mh = 3; mm = 0; ms = 0;
      end else if (dstEnable && fall && mfd == 0) begin
        mm = 0; ms = 0; mfd = 1;
      end else begin
        if (fall && mfd == 1) mfd = 0;
        ms++;
        if (ms == 60) begin
          ms = 0; mm++;
          if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
              mh = 0;
              mdw = (mdw % 7) + 1;
              mdt++;
              if (mdt > daysIn(mmo, my)) begin
                mdt = 1; mmo++;
                if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
              end
            end
          end
        end
      end
    end else if (wrEn && holdUpdate) begin
      mfd = 0;
      case (int'(wrSel))
        0: ms  = readIn(wrData);
        1: mm  = readIn(wrData);
        2: begin
          if (mode24) mh = readIn(wrData);
          else begin
            int low;
            low = bcdMode ? binOf(wrData % 128) : (wrData % 128);
            mh  = (low == 12 ? 0 : low) + (wrData[7] ? 12 : 0);
          end
        end
        3: mdw = readIn(wrData);
        4: mdt = readIn(wrData);
        5: mmo = readIn(wrData);
        6: my  = readIn(wrData);
        default: ;
      endcase
    end
  endtask

  task automatic check(string name, logic [7:0] act, int exp);
    vectors++;
    if (act !== 8'(exp)) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", phase, name, act, 8'(exp));
    end
  endtask

  always @(posedge clk) begin
    modelStep();
    #5;
    if (!finished) begin
      check("seconds", secondsOut, view(ms));
      check("minutes", minutesOut, view(mm));
      check("hours",   hoursOut,   hourView());
      check("weekday", weekdayOut, view(mdw));
      check("date",    dateOut,    view(mdt));
      check("month",   monthOut,   view(mmo));
      check("year",    yearOut,    view(my));
      check("updateDone", {7'b0, updateDone}, mupd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    @(negedge clk) secTick = 1'b1;
    repeat (n) @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic put(int sel, int d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'(sel); wrData = 8'(d);
    @(negedge clk) wrEn = 1'b0;
  endtask

  task automatic loadAll(int y, int mo, int dt, int dw, int h, int m, int s);
    @(negedge clk) holdUpdate = 1'b1;
    put(6, y); put(5, mo); put(4, dt); put(3, dw); put(2, h); put(1, m); put(0, s);
    @(negedge clk) holdUpdate = 1'b0;
  endtask

  task automatic finish();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; secTick = 1'b0; holdUpdate = 1'b0; bcdMode = 1'b0; mode24 = 1'b1;
    dstEnable = 1'b0; wrEn = 1'b0; wrSel = 3'd0; wrData = 8'd0;
    idle(3);
    @(negedge clk) rstN = 1'b1;
    idle(2);

    phase = "R1 R9 single ticks";
    ticks(1); idle(2); ticks(1); idle(1);
    phase = "R1 R9 minute and hour carries";
    ticks(3700); idle(2);

    phase = "R7 ticks during hold";
    @(negedge clk) holdUpdate = 1'b1;
    ticks(5); idle(1);
    @(negedge clk) holdUpdate = 1'b0;

    phase = "R8 write without hold";
    @(negedge clk); wrEn = 1'b1; wrSel = 3'd0; wrData = 8'd33;
    idle(1); wrSel = 3'd6; idle(1);
    wrEn = 1'b0; idle(2);

    phase = "R2 R4 century end";
    loadAll(99, 12, 31, 7, 23, 59, 55); ticks(10); idle(1);
    phase = "R2 thirty-day month";
    loadAll(21, 4, 30, 3, 23, 59, 59); ticks(2);
    loadAll(21, 11, 30, 5, 23, 59, 59); ticks(2);
    phase = "R2 thirty-one-day month";
    loadAll(21, 1, 31, 4, 23, 59, 59); ticks(2);
    loadAll(21, 1, 30, 4, 23, 59, 59); ticks(2);

    phase = "R3 leap February";
    loadAll(24, 2, 28, 2, 23, 59, 58); ticks(3);
    loadAll(24, 2, 29, 3, 23, 59, 58); ticks(3);
    loadAll(0, 2, 28, 6, 23, 59, 58);  ticks(3);
    phase = "R3 common February";
    loadAll(23, 2, 28, 3, 23, 59, 58); ticks(3);

    phase = "R5 BCD view";
    @(negedge clk) bcdMode = 1'b1;
    idle(2);
    loadAll('h99, 'h12, 'h31, 'h07, 'h23, 'h59, 'h48); ticks(15);
    loadAll('h47, 'h09, 'h30, 'h02, 'h19, 'h09, 'h59); ticks(2);

    phase = "R6 12-hour BCD";
    @(negedge clk) mode24 = 1'b0;
    idle(2);
    loadAll('h30, 'h06, 'h15, 'h02, 'h91, 'h59, 'h58); ticks(3);
    loadAll('h30, 'h06, 'h15, 'h02, 'h11, 'h59, 'h58); ticks(3);
    loadAll('h30, 'h06, 'h15, 'h02, 'h12, 'h00, 'h05); ticks(2);
    phase = "R6 12-hour binary";
    @(negedge clk) bcdMode = 1'b0;
    loadAll(30, 6, 15, 2, 'h8B, 59, 58); ticks(3);
    loadAll(30, 6, 15, 2, 'h8C, 59, 58); ticks(3);
    @(negedge clk) mode24 = 1'b1;
    idle(2);

    phase = "R10 spring shift";
    @(negedge clk) dstEnable = 1'b1;
    loadAll(26, 4, 5, 1, 1, 59, 50); ticks(15);
    phase = "R10 no shift off Sunday";
    loadAll(26, 4, 6, 2, 1, 59, 50); ticks(15);

    phase = "R11 fall repeat";
    loadAll(26, 10, 25, 1, 1, 59, 50); ticks(15);
    phase = "R11 second pass continues";
    ticks(3600); idle(2);
    phase = "R11 disabled rule";
    @(negedge clk) dstEnable = 1'b0;
    loadAll(26, 10, 31, 1, 1, 59, 55); ticks(10);
    idle(3);
    finish();
  end

endmodule